// File: doc/BRIEF.md
# Photon acquisition cycle sequencer

This block paces one acquisition cycle of a photon-counting sensor on a 5 ns system clock. It idles in a ready state until a trigger arrives. It then opens a validation window and watches the running photon count. If the count reaches the selected threshold inside the window, the event is treated as real. The sequencer runs a programmable light-collection period, then a readout period of fixed minimum length, and then a short recharge. If the window closes without the threshold being met, the event is taken to be a dark count. The sequencer then drops straight into recharge, and no readout or data latch takes place.

The validation step can be switched off, in which case a trigger leads directly to collection. The configuration is captured at the moment a trigger is accepted, so software may rewrite it at any time without disturbing a cycle in flight. The data-latch strobe fires as readout finishes. This lets the downstream data path move the previous event's data out while the next acquisition runs. Readout is held open until that path signals it is done.

Top module: `acq_seq`

## Requirements
- R1: While reset is high, and on the first cycle after reset falls, only the ready indicator is high. Both strobes are low. A reset taken in the middle of a cycle returns the block to ready.
- R2: In ready, the block stays in ready while the trigger is low. A trigger taken in ready with a non-zero threshold select enters validation on the next cycle. Triggers seen in any other state have no effect.
- R3: Threshold select 0 bypasses validation, so a trigger goes straight to collection, or to readout when the collection length is 0. A select value k from 1 to 7 needs a photon count of at least 2^(k+1): 4, 8, 16, 32, 64, 128 or 256. The value 256 can never be met by the 8-bit count.
- R4: A validation window field v gives at most v+1 validation cycles. In the first of those cycles where the count is at least the threshold, the block leaves validation and enters collection on the next cycle.
- R5: If none of the v+1 validation cycles meets the threshold, the block enters recharge. The recharge strobe pulses in the first recharge cycle, and the latch strobe stays low.
- R6: Collection lasts exactly cfg_coll cycles, from 0 to 4095. A value of 0 skips collection and goes from a passed validation (or a bypassed trigger) directly into readout.
- R7: Readout lasts at least READ_CYC cycles (136 by default, 680 ns). After that it continues until rd_done_i is sampled high.
- R8: When readout ends, the block enters recharge. The recharge strobe and the latch strobe are both high for the first recharge cycle only.
- R9: Recharge lasts min(cfg_rch, 6) + 2 cycles, which is 10 to 40 ns, and then the block returns to ready.
- R10: The threshold select, window, collection and recharge fields are captured on the clock edge that accepts a trigger. Changing them later has no effect on that acquisition.
- R11: Exactly one of the five state indicators is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Event trigger, acted on only in ready |
| phot_cnt_i | input | CNT_W (8) | Running photon count of the current event |
| rd_done_i | input | 1 | Downstream data path has finished; ends readout once the minimum has elapsed |
| cfg_thr_sel_i | input | SEL_W (3) | 0 = bypass validation, k = threshold 2^(k+1) |
| cfg_vwin_i | input | VWIN_W (4) | Validation window length minus one, in cycles |
| cfg_coll_i | input | COLL_W (12) | Collection length in cycles |
| cfg_rch_i | input | RCH_W (3) | Recharge length code, length = min(code,6)+2 cycles |
| rdy_o | output | 1 | In ready state |
| val_o | output | 1 | In validation state |
| coll_o | output | 1 | In collection state |
| rdout_o | output | 1 | In readout state |
| rch_o | output | 1 | In recharge state |
| rch_stb_o | output | 1 | One-cycle pulse on entry to recharge |
| lat_stb_o | output | 1 | One-cycle data-latch pulse when readout ends |

## Verification
Two cases are hardest to reach from the ports. One is a threshold that is first met exactly in the last validation cycle, against one that is met a single cycle too late. The other is a configuration rewrite during a cycle that is already in flight. The stimulus raises the photon count at a chosen cycle offset after the trigger, with the window set to its largest value and offsets of 15 and 16. In separate events it rewrites every configuration field on each cycle while also firing stray triggers. A behavioural model of the cycle is compared against all outputs on every clock. That model keeps the values it captured when the trigger was accepted.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE = 5'b00001,
    ST_VALD = 5'b00010,
    ST_COLL = 5'b00100,
    ST_READ = 5'b01000,
    ST_RCHG = 5'b10000
  } acq_st_e;

  typedef enum logic [1:0] {
    LD_VWIN = 2'd0,
    LD_COLL = 2'd1,
    LD_READ = 2'd2,
    LD_RCHG = 2'd3
  } ld_sel_e;

endpackage

// File: rtl/acq_cfg_reg.sv
module acq_cfg_reg #(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 3,
  parameter int VWIN_W   = 4,
  parameter int COLL_W   = 12,
  parameter int RCH_W    = 3,
  parameter int RCH_MIN  = 2,
  parameter int RCH_SPAN = 6,
  parameter int TMR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [VWIN_W-1:0] vwin_i,
  input  logic [COLL_W-1:0] coll_i,
  input  logic [RCH_W-1:0]  rch_i,
  output logic [CNT_W:0]    thr_o,
  output logic              bypass_o,
  output logic [TMR_W-1:0]  vwin_ld_o,
  output logic              coll_zero_o,
  output logic [TMR_W-1:0]  coll_ld_o,
  output logic [TMR_W-1:0]  rch_ld_o
);

  logic [SEL_W-1:0]  sel_q;
  logic [VWIN_W-1:0] vwin_q;
  logic [COLL_W-1:0] coll_q;
  logic [RCH_W-1:0]  rch_q;

  logic [SEL_W-1:0]  sel_e;
  logic [VWIN_W-1:0] vwin_e;
  logic [COLL_W-1:0] coll_e;
  logic [RCH_W-1:0]  rch_e;
  int unsigned       rch_cyc;

  // shadow copy, written only on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      vwin_q <= '0;
      coll_q <= '0;
      rch_q  <= '0;
    end else if (cap_i) begin
      sel_q  <= sel_i;
      vwin_q <= vwin_i;
      coll_q <= coll_i;
      rch_q  <= rch_i;
    end
  end

  // on the accepting cycle the live fields decide the first step
  always_comb begin
    sel_e  = cap_i ? sel_i  : sel_q;
    vwin_e = cap_i ? vwin_i : vwin_q;
    coll_e = cap_i ? coll_i : coll_q;
    rch_e  = cap_i ? rch_i  : rch_q;
  end

  always_comb begin
    thr_o       = (CNT_W+1)'(2) << sel_e;
    bypass_o    = (sel_e == '0);
    vwin_ld_o   = TMR_W'(vwin_e);
    coll_zero_o = (coll_e == '0);
    coll_ld_o   = TMR_W'(coll_e - 1'b1);
    rch_cyc     = (int'(rch_e) > RCH_SPAN) ? RCH_SPAN : int'(rch_e);
    rch_ld_o    = TMR_W'(rch_cyc + RCH_MIN - 1);
  end

endmodule

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [TMR_W-1:0] ld_val_i,
  output logic             zero_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ld_i)
      cnt_q <= ld_val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             done_i,
  input  logic [CNT_W:0]   thr_i,
  input  logic             bypass_i,
  input  logic             coll_zero_i,
  input  logic             tmr_zero_i,
  output acq_st_e          st_o,
  output logic             ld_o,
  output ld_sel_e          ld_sel_o,
  output logic             cap_o,
  output logic             rch_stb_o,
  output logic             lat_stb_o
);

  acq_st_e st_q, st_d;
  logic    to_rch, from_read, pass;

  always_comb begin
    st_d      = st_q;
    ld_o      = 1'b0;
    ld_sel_o  = LD_VWIN;
    cap_o     = 1'b0;
    to_rch    = 1'b0;
    from_read = 1'b0;
    pass      = ({1'b0, cnt_i} >= thr_i);
    unique case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          cap_o = 1'b1;
          ld_o  = 1'b1;
          if (!bypass_i) begin
            st_d     = ST_VALD;
            ld_sel_o = LD_VWIN;
          end else if (coll_zero_i) begin
            st_d     = ST_READ;
            ld_sel_o = LD_READ;
          end else begin
            st_d     = ST_COLL;
            ld_sel_o = LD_COLL;
          end
        end
      end
      ST_VALD: begin
        if (pass) begin
          ld_o = 1'b1;
          if (coll_zero_i) begin
            st_d     = ST_READ;
            ld_sel_o = LD_READ;
          end else begin
            st_d     = ST_COLL;
            ld_sel_o = LD_COLL;
          end
        end else if (tmr_zero_i) begin
          st_d     = ST_RCHG;
          ld_o     = 1'b1;
          ld_sel_o = LD_RCHG;
          to_rch   = 1'b1;
        end
      end
      ST_COLL: begin
        if (tmr_zero_i) begin
          st_d     = ST_READ;
          ld_o     = 1'b1;
          ld_sel_o = LD_READ;
        end
      end
      ST_READ: begin
        if (tmr_zero_i && done_i) begin
          st_d      = ST_RCHG;
          ld_o      = 1'b1;
          ld_sel_o  = LD_RCHG;
          to_rch    = 1'b1;
          from_read = 1'b1;
        end
      end
      ST_RCHG: begin
        if (tmr_zero_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      rch_stb_o <= 1'b0;
      lat_stb_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      rch_stb_o <= to_rch;
      lat_stb_o <= from_read;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 3,
  parameter int VWIN_W   = 4,
  parameter int COLL_W   = 12,
  parameter int RCH_W    = 3,
  parameter int RCH_MIN  = 2,
  parameter int RCH_SPAN = 6,
  parameter int READ_CYC = 136
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  phot_cnt_i,
  input  logic              rd_done_i,
  input  logic [SEL_W-1:0]  cfg_thr_sel_i,
  input  logic [VWIN_W-1:0] cfg_vwin_i,
  input  logic [COLL_W-1:0] cfg_coll_i,
  input  logic [RCH_W-1:0]  cfg_rch_i,
  output logic              rdy_o,
  output logic              val_o,
  output logic              coll_o,
  output logic              rdout_o,
  output logic              rch_o,
  output logic              rch_stb_o,
  output logic              lat_stb_o
);

  localparam int RD_BITS = $clog2(READ_CYC + 1);
  localparam int TMR_W   = (COLL_W > RD_BITS) ? COLL_W : RD_BITS;

  acq_st_e          st;
  ld_sel_e          ld_sel;
  logic             ld, cap, tmr_zero, bypass, coll_zero;
  logic [CNT_W:0]   thr;
  logic [TMR_W-1:0] vwin_ld, coll_ld, rch_ld, ld_val;

  acq_cfg_reg #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .VWIN_W(VWIN_W), .COLL_W(COLL_W),
    .RCH_W(RCH_W), .RCH_MIN(RCH_MIN), .RCH_SPAN(RCH_SPAN), .TMR_W(TMR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cap_i(cap),
    .sel_i(cfg_thr_sel_i), .vwin_i(cfg_vwin_i), .coll_i(cfg_coll_i), .rch_i(cfg_rch_i),
    .thr_o(thr), .bypass_o(bypass), .vwin_ld_o(vwin_ld),
    .coll_zero_o(coll_zero), .coll_ld_o(coll_ld), .rch_ld_o(rch_ld)
  );

  always_comb begin
    unique case (ld_sel)
      LD_VWIN: ld_val = vwin_ld;
      LD_COLL: ld_val = coll_ld;
      LD_READ: ld_val = TMR_W'(READ_CYC - 1);
      default: ld_val = rch_ld;
    endcase
  end

  acq_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .ld_i(ld), .ld_val_i(ld_val), .zero_o(tmr_zero)
  );

  acq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .trig_i(trig_i), .cnt_i(phot_cnt_i), .done_i(rd_done_i),
    .thr_i(thr), .bypass_i(bypass), .coll_zero_i(coll_zero), .tmr_zero_i(tmr_zero),
    .st_o(st), .ld_o(ld), .ld_sel_o(ld_sel), .cap_o(cap),
    .rch_stb_o(rch_stb_o), .lat_stb_o(lat_stb_o)
  );

  assign rdy_o   = (st == ST_IDLE);
  assign val_o   = (st == ST_VALD);
  assign coll_o  = (st == ST_COLL);
  assign rdout_o = (st == ST_READ);
  assign rch_o   = (st == ST_RCHG);

endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int SEL_W    = 3,
  parameter int READ_CYC = 136
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_i,
  input logic             rd_done_i,
  input logic [SEL_W-1:0] cfg_thr_sel_i,
  input logic             rdy_o,
  input logic             val_o,
  input logic             coll_o,
  input logic             rdout_o,
  input logic             rch_o,
  input logic             rch_stb_o,
  input logic             lat_stb_o
);

  int unsigned rd_run;

  always_ff @(posedge clk) begin
    if (rst)          rd_run <= 0;
    else if (rdout_o) rd_run <= rd_run + 1;
    else              rd_run <= 0;
  end

  // R11
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({rdy_o, val_o, coll_o, rdout_o, rch_o}));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_o && !trig_i |=> rdy_o);

  // R2
  trig_to_val_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_o && trig_i && (cfg_thr_sel_i != '0) |=> val_o);

  // R3
  bypass_skip_chk: assert property (@(posedge clk) disable iff (rst)
    rdy_o && trig_i && (cfg_thr_sel_i == '0) |=> (coll_o || rdout_o));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rdout_o && !rd_done_i |=> rdout_o);

  // R7
  rd_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdout_o) |-> (rd_run >= READ_CYC));

  // R8
  latch_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    lat_stb_o |-> (rch_o && rch_stb_o && $past(rdout_o)));

  // R5
  rch_entry_stb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rch_o) |-> rch_stb_o);

  // R5
  dark_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rch_o) && $past(val_o) |-> !lat_stb_o);

endmodule

bind acq_seq acq_seq_chk #(.SEL_W(SEL_W), .READ_CYC(READ_CYC)) u_acq_chk (
  .clk(clk), .rst(rst), .trig_i(trig_i), .rd_done_i(rd_done_i),
  .cfg_thr_sel_i(cfg_thr_sel_i), .rdy_o(rdy_o), .val_o(val_o), .coll_o(coll_o),
  .rdout_o(rdout_o), .rch_o(rch_o), .rch_stb_o(rch_stb_o), .lat_stb_o(lat_stb_o)
);

// File: tb/test_acq_seq.sv
module test_acq_seq;

  localparam int READ_CYC = 136;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [7:0]  phot = '0;
  logic        rd_done = 1'b1;
  logic [2:0]  sel = 3'd1;
  logic [3:0]  vw = '0;
  logic [11:0] co = 12'd1;
  logic [2:0]  rc = '0;
  logic rdy_o, val_o, coll_o, rdout_o, rch_o, rch_stb_o, lat_stb_o;

  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  bit    live    = 0;
  bit    done    = 0;
  string scen    = "R1";

  // model: 0 ready, 1 validation, 2 collection, 3 readout, 4 recharge
  int m_st = 0, m_left = 0, m_thr = 0, m_coll = 0, m_rch = 2;
  bit e_rs = 0, e_lat = 0;

  acq_seq i_acq_seq (
    .clk(clk), .rst(rst), .trig_i(trig), .phot_cnt_i(phot), .rd_done_i(rd_done),
    .cfg_thr_sel_i(sel), .cfg_vwin_i(vw), .cfg_coll_i(co), .cfg_rch_i(rc),
    .rdy_o(rdy_o), .val_o(val_o), .coll_o(coll_o), .rdout_o(rdout_o), .rch_o(rch_o),
    .rch_stb_o(rch_stb_o), .lat_stb_o(lat_stb_o)
  );

  always #5 clk = ~clk;

  task automatic enter_pass();
    if (m_coll == 0) begin m_st = 3; m_left = READ_CYC; end
    else begin m_st = 2; m_left = m_coll; end
  endtask

  always @(posedge clk) begin
    cyc++;
    e_rs  = 0;
    e_lat = 0;
    if (rst) begin
      m_st = 0; m_left = 0; live = 1;
    end else begin
      case (m_st)
        0: if (trig) begin
             m_thr  = (sel == 0) ? 0 : (1 << (int'(sel) + 1));
             m_coll = int'(co);
             m_rch  = ((rc > 6) ? 6 : int'(rc)) + 2;
             if (sel == 0) enter_pass();
             else begin m_st = 1; m_left = int'(vw) + 1; end
           end
        1: if (int'(phot) >= m_thr) enter_pass();
           else begin
             m_left--;
             if (m_left == 0) begin m_st = 4; m_left = m_rch; e_rs = 1; end
           end
        2: begin m_left--; if (m_left == 0) begin m_st = 3; m_left = READ_CYC; end end
        3: if (m_left > 1) m_left--;
           else if (rd_done) begin m_st = 4; m_left = m_rch; e_rs = 1; e_lat = 1; end
        default: begin m_left--; if (m_left == 0) m_st = 0; end
      endcase
    end
  end

  function automatic string st_req(int s);
    case (s)
      0: return "R2";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (live && !done) begin
      logic [4:0] act, exp_v;
      act   = {rch_o, rdout_o, coll_o, val_o, rdy_o};
      exp_v = 5'b00001 << m_st;
      vectors++;
      if (act !== exp_v) begin
        errors++;
        $display("FAIL %s (scenario %s) state act=%b exp=%b t=%0t", st_req(m_st), scen, act, exp_v, $time);
      end
      vectors++;
      if (rch_stb_o !== e_rs) begin
        errors++;
        $display("FAIL R5 (scenario %s) rch_stb act=%b exp=%b t=%0t", scen, rch_stb_o, e_rs, $time);
      end
      vectors++;
      if (lat_stb_o !== e_lat) begin
        errors++;
        $display("FAIL R8 (scenario %s) lat_stb act=%b exp=%b t=%0t", scen, lat_stb_o, e_lat, $time);
      end
      vectors++;
      if ($countones(act) != 1) begin
        errors++;
        $display("FAIL R11 (scenario %s) indicators act=%b exp=one-hot", scen, act);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check_reset_state();
    vectors++;
    if ({rch_o, rdout_o, coll_o, val_o, rdy_o, rch_stb_o, lat_stb_o} !== 7'b0000100) begin
      errors++;
      $display("FAIL R1 reset state act=%b exp=%b",
               {rch_o, rdout_o, coll_o, val_o, rdy_o, rch_stb_o, lat_stb_o}, 7'b0000100);
    end
  endtask

  // one acquisition; d = validation cycle at which the count appears,
  // rw = readout cycles before rd_done rises, noise = stray triggers and cfg rewrites
  task automatic ev(input int s, input int v, input int c, input int r, input int n,
                    input int d, input int rw, input bit noise);
    int rdc = 0;
    @(negedge clk);
    while (!rdy_o) @(negedge clk);
    sel = 3'(s); vw = 4'(v); co = 12'(c); rc = 3'(r);
    trig = 1'b1; phot = '0; rd_done = (rw == 0);
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (rdy_o) begin trig = 1'b0; phot = '0; break; end
      trig = noise && (k % 3 == 0) && !rch_o;
      if (noise) begin
        sel = 3'(k); vw = 4'(k); co = 12'(k * 7); rc = 3'(k + 1);
      end
      phot = (k >= d) ? 8'(n) : 8'd0;
      if (rdout_o) rdc++;
      rd_done = (rdc >= rw);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();          // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();          // R1 after release
    scen = "R2";
    repeat (5) @(negedge clk);    // idle without trigger
    scen = "R4";
    ev(1, 3, 10, 0, 4, 2, 0, 0);
    ev(5, 15, 3, 1, 64, 15, 0, 0); // met in last window cycle
    ev(5, 15, 3, 1, 64, 16, 0, 0); // one cycle too late
    ev(5, 15, 3, 1, 63, 0, 0, 0);  // just below threshold
    scen = "R5";
    ev(2, 5, 8, 3, 7, 0, 0, 0);
    scen = "R3";
    ev(0, 2, 5, 2, 0, 0, 0, 0);    // bypass
    ev(7, 4, 2, 0, 255, 0, 0, 0);  // unreachable threshold
    ev(1, 0, 2, 0, 4, 0, 0, 0);    // single-cycle window
    ev(6, 2, 2, 0, 128, 1, 0, 0);
    scen = "R6";
    ev(3, 2, 0, 0, 16, 1, 0, 0);
    ev(0, 0, 0, 0, 0, 0, 0, 0);
    ev(4, 1, 4000, 0, 200, 0, 0, 0);
    scen = "R7";
    ev(1, 2, 3, 0, 9, 0, 150, 0);
    ev(1, 2, 3, 0, 9, 0, 136, 0);
    scen = "R8";
    ev(2, 1, 1, 4, 8, 0, 0, 0);
    scen = "R9";
    ev(1, 1, 2, 7, 9, 0, 0, 0);
    ev(2, 0, 1, 6, 0, 0, 0, 0);
    ev(1, 1, 1, 5, 4, 0, 0, 0);
    scen = "R10";
    ev(2, 6, 20, 1, 10, 3, 0, 1);
    ev(0, 3, 9, 5, 0, 0, 0, 1);
    ev(4, 9, 2, 2, 1, 0, 0, 1);    // dark event with rewrites
    scen = "R1";
    @(negedge clk);
    sel = 3'd1; vw = 4'd2; co = 12'd50; trig = 1'b1; phot = 8'd20;
    @(negedge clk);
    trig = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();          // R1 mid-cycle reset
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule